// File: doc/BRIEF.md
# Multi-Register Byte Table Lookup Unit

This unit performs a parallel byte lookup on a 128-bit vector. Each of the 16 index bytes picks one byte out of a table. The table is formed by concatenating one to four 128-bit table registers, so it holds 16, 32, 48 or 64 entries. A mode field sets what happens to a lane whose index falls outside the table:

- the lane can be cleared to zero,
- it can keep the matching byte of a supplied destination vector, so that lookups into larger tables can be chained across several operations, or
- it can follow a sign-bit rule, where only bit 7 of the index clears the lane and the low four bits address a single 16-entry register.

An operation is offered on a valid/ready port and is taken when both signals are high. Its result appears in an output register one cycle later. That register holds its value while the consumer stalls, and the unit refuses new operations until the held result has been taken.

Top module: `vec_byte_lut`

## Requirements
- R1: Result byte i (bits 8i+7:8i of `res_data`) equals table entry k, where k is the unsigned value of index byte i. Entry k sits at bits 8k+7:8k of `op_table`, so register r holds entries 16r to 16r+15.
- R2: `op_nregs` value n (0 to 3) makes the table n+1 registers long, giving 16(n+1) entries. An index is in range when its unsigned value is below that length.
- R3: In clearing mode (`op_mode` 0, and also the spare code 3), a lane whose index is not below the table length gives 0.
- R4: In keep mode (`op_mode` 1), a lane whose index is out of range gives byte i of `op_dest`. In-range lanes follow R1.
- R5: In sign-bit mode (`op_mode` 2), a lane whose index has bit 7 set gives 0. Otherwise the lane gives entry idx[3:0] of register 0. Index bits 6:4 and `op_nregs` have no effect in this mode.
- R6: Adding 112 to every index byte with unsigned saturation, then looking up in sign-bit mode, gives the same vector as clearing mode with a 16-entry table.
- R7: An operation is accepted on a rising edge where `op_valid` and `op_ready` are both high. `res_valid` is high from the next cycle, and `res_data` then carries that operation's result.
- R8: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` keep their values. `res_valid` falls only after a cycle in which `res_ready` was high.
- R9: A synchronous active-high `rst` clears `res_valid` and `res_data` to 0.
- R10: `op_ready` is high exactly when there is no held result or `res_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_index | input | 128 | Sixteen index bytes |
| op_table | input | 512 | Four table registers; register r at bits 128r+127:128r |
| op_nregs | input | 2 | Table register count minus one |
| op_mode | input | 2 | 0 clear, 1 keep destination, 2 sign-bit, 3 clear |
| op_dest | input | 128 | Destination bytes kept in keep mode |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 128 | Registered result vector |

## Verification
The assertions assume the consumer follows the valid/ready rules. They also assume that `op_valid` is driven to a known level at every edge after reset. The bench drives all inputs at falling edges and keeps `op_valid` low between operations. It moves `res_ready` only while no acceptance is due at the next edge, apart from the stall release, which is checked directly. The lookup itself is checked against a model in the bench. That model walks the table as a byte array and does not slice vectors.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  localparam int LANES    = 16;
  localparam int BW       = 8;
  localparam int MAX_REGS = 4;
  localparam int VEC_W    = LANES * BW;
  localparam int TBL_W    = VEC_W * MAX_REGS;
  localparam int ENTRIES  = LANES * MAX_REGS;
  localparam int SEL_W    = $clog2(ENTRIES);
  localparam int LO_W     = $clog2(LANES);
  localparam int NREG_W   = $clog2(MAX_REGS);

  typedef enum logic [1:0] {
    VBL_CLEAR  = 2'd0,
    VBL_KEEP   = 2'd1,
    VBL_SIGN   = 2'd2,
    VBL_CLEAR2 = 2'd3
  } vbl_mode_e;

  // Number of live table entries for a register count code.
  function automatic logic [BW:0] vbl_len(input logic [NREG_W-1:0] n);
    return (BW+1)'((32'(n) + 1) * LANES);
  endfunction

  // Unsigned range test of one index byte.
  function automatic logic vbl_in_range(input logic [BW-1:0] idx,
                                        input logic [NREG_W-1:0] n);
    return {1'b0, idx} < vbl_len(n);
  endfunction
endpackage

// File: rtl/vbl_lane_sel.sv
module vbl_lane_sel
  import vbl_pkg::*;
(
  input  logic [TBL_W-1:0]  tbl,
  input  logic [BW-1:0]     idx,
  input  logic [NREG_W-1:0] nregs,
  input  logic [1:0]        mode,
  input  logic [BW-1:0]     dest,
  output logic [BW-1:0]     out_byte
);
  logic          in_range;
  logic          sign_zero;
  logic [SEL_W-1:0] wide_sel;
  logic [LO_W-1:0]  lo_sel;
  logic [BW-1:0] wide_byte;
  logic [BW-1:0] lo_byte;

  assign in_range  = vbl_in_range(idx, nregs);
  assign sign_zero = idx[BW-1];
  assign wide_sel  = idx[SEL_W-1:0];
  assign lo_sel    = idx[LO_W-1:0];
  assign wide_byte = tbl[BW*wide_sel +: BW];
  assign lo_byte   = tbl[BW*lo_sel +: BW];

  always_comb begin
    unique case (vbl_mode_e'(mode))
      VBL_KEEP: out_byte = in_range ? wide_byte : dest;
      VBL_SIGN: out_byte = sign_zero ? '0 : lo_byte;
      default:  out_byte = in_range ? wide_byte : '0;
    endcase
  end
endmodule

// File: rtl/vbl_out_stage.sv
module vbl_out_stage
  import vbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  drop_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_ready));

  // R10
  ready_low_only_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));
endmodule

// File: rtl/vec_byte_lut.sv
module vec_byte_lut
  import vbl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [VEC_W-1:0]   op_index,
  input  logic [TBL_W-1:0]   op_table,
  input  logic [NREG_W-1:0]  op_nregs,
  input  logic [1:0]         op_mode,
  input  logic [VEC_W-1:0]   op_dest,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [VEC_W-1:0]   res_data
);
  logic [VEC_W-1:0] lane_result;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vbl_lane_sel u_lane (
      .tbl      (op_table),
      .idx      (op_index[g*BW +: BW]),
      .nregs    (op_nregs),
      .mode     (op_mode),
      .dest     (op_dest[g*BW +: BW]),
      .out_byte (lane_result[g*BW +: BW])
    );
  end

  vbl_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (op_valid),
    .in_ready  (op_ready),
    .in_data   (lane_result),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (res_data)
  );
endmodule

// File: tb/vec_byte_lut_bench.sv
module vec_byte_lut_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [127:0] op_index = '0;
  logic [511:0] op_table;
  logic [1:0]   op_nregs = '0;
  logic [1:0]   op_mode = '0;
  logic [127:0] op_dest;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [127:0] res_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vec_byte_lut u_vec_byte_lut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_index(op_index), .op_table(op_table), .op_nregs(op_nregs),
    .op_mode(op_mode), .op_dest(op_dest), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  // Rows: {mode, nregs, index base, index step}
  localparam logic [19:0] ROWS [12] = '{
    {2'd0, 2'd0, 8'd0,   8'd1},
    {2'd0, 2'd0, 8'd8,   8'd1},
    {2'd0, 2'd1, 8'd10,  8'd2},
    {2'd0, 2'd3, 8'd0,   8'd4},
    {2'd0, 2'd2, 8'd40,  8'd1},
    {2'd1, 2'd0, 8'd10,  8'd3},
    {2'd1, 2'd1, 8'd24,  8'd1},
    {2'd1, 2'd3, 8'd50,  8'd1},
    {2'd2, 2'd0, 8'h70,  8'd9},
    {2'd2, 2'd3, 8'h35,  8'h11},
    {2'd3, 2'd1, 8'd28,  8'd1},
    {2'd0, 2'd3, 8'hF0,  8'd1}
  };

  function automatic logic [7:0] entry(int k);
    return 8'(8'h40 + 3 * k);
  endfunction

  function automatic logic [127:0] model(logic [127:0] idxv, int n, int mode,
                                         logic [127:0] dv);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      int v;
      v = idxv[i*8 +: 8];
      if (mode == 2) r[i*8 +: 8] = (v >= 128) ? 8'h00 : entry(v % 16);
      else if (v < 16 * (n + 1)) r[i*8 +: 8] = entry(v);
      else if (mode == 1) r[i*8 +: 8] = dv[i*8 +: 8];
      else r[i*8 +: 8] = 8'h00;
    end
    return r;
  endfunction

  function automatic logic [127:0] ramp(logic [7:0] base, logic [7:0] step);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = 8'(base + step * i);
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [127:0] idxv, logic [1:0] n, logic [1:0] m);
    @(negedge clk);
    op_index = idxv; op_nregs = n; op_mode = m; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 64; k++) op_table[k*8 +: 8] = entry(k);
    for (int i = 0; i < 16; i++) op_dest[i*8 +: 8] = 8'(8'hD0 + i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 / R10 reset state
    check("R9", 128'(res_valid), 128'd0);
    check("R9", res_data, 128'd0);
    check("R10", 128'(op_ready), 128'd1);

    // Vector walk: R1..R5
    for (int r = 0; r < 12; r++) begin
      logic [127:0] iv;
      int m, n;
      m = ROWS[r][19:18]; n = ROWS[r][17:16];
      iv = ramp(ROWS[r][15:8], ROWS[r][7:0]);
      issue(iv, 2'(n), 2'(m));
      check("R7", 128'(res_valid), 128'd1);
      case (m)
        1: check("R4", res_data, model(iv, n, m, op_dest));
        2: check("R5", res_data, model(iv, n, m, op_dest));
        default: check(n == 0 ? "R1" : "R2_R3", res_data, model(iv, n, m, op_dest));
      endcase
    end

    // R6 saturating-add equivalence
    for (int t = 0; t < 3; t++) begin
      logic [127:0] iv, sv, zres;
      iv = ramp(8'(t * 7), 8'(t * 5 + 3));
      for (int i = 0; i < 16; i++)
        sv[i*8 +: 8] = (iv[i*8 +: 8] > 8'd143) ? 8'hFF : 8'(iv[i*8 +: 8] + 8'd112);
      issue(iv, 2'd0, 2'd0);
      zres = res_data;
      issue(sv, 2'(t), 2'd2);
      check("R6", res_data, zres);
    end

    // R8 / R10 stall
    @(negedge clk);
    res_ready = 1'b0;
    op_index = ramp(8'd0, 8'd1); op_nregs = 2'd0; op_mode = 2'd0; op_valid = 1'b1;
    @(negedge clk);
    check("R10", 128'(op_ready), 128'd0);
    check("R8", res_data, model(ramp(8'd0, 8'd1), 0, 0, op_dest));
    op_index = ramp(8'd20, 8'd1); op_nregs = 2'd3;
    @(negedge clk);
    check("R8", res_data, model(ramp(8'd0, 8'd1), 0, 0, op_dest));
    check("R8", 128'(res_valid), 128'd1);
    res_ready = 1'b1;
    #1;
    check("R10", 128'(op_ready), 128'd1);
    @(negedge clk);
    op_valid = 1'b0;
    check("R7", res_data, model(ramp(8'd20, 8'd1), 3, 0, op_dest));
    @(negedge clk);
    check("R8", 128'(res_valid), 128'd0);

    // R9 reset while holding a result
    res_ready = 1'b0;
    issue(ramp(8'd1, 8'd1), 2'd0, 2'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    res_ready = 1'b1;
    check("R9", 128'(res_valid), 128'd0);
    check("R9", res_data, 128'd0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule